// File: doc/BRIEF.md
# Parallel Bus Frame Transmitter

This block accepts a byte stream, holds the bytes in a small internal FIFO, and sends them out as a frame over a parallel bus. The bus uses 1, 2, 4, 8 or 16 active lines, chosen per frame. Narrow widths cut each byte into slices and send one slice per clock. The 16-line width sends two bytes per clock. Between frames the bus drives a programmable idle pattern.

The top line of the bus can carry a strobe in place of data. In valid mode it is high exactly while a beat is on the bus. In clock-gate mode it carries the same strobe and also drives a clock enable for the outgoing bus clock.

A frame ends in one of two ways. In length mode it ends after a programmed number of bits. In marker mode it ends after the byte that carries the upstream last flag. Two sticky events report the end of a frame and a FIFO that runs dry in the middle of a frame. Each event has an enable and is cleared by writing 1.

Top module: `par_frame_tx`

## Requirements
- R1: `cfg_width` selects the active lines as code 0=1, 1=2, 2=4, 3=8, 4=16 (codes 5 to 7 behave as 4). During a beat, the lines above the active width are 0. At width 16 each beat carries two bytes: the earlier byte on lines 7:0 and the later byte on lines 15:8. A lone final byte is sent with lines 15:8 at 0.
- R2: For widths below 8, let L be the number of lines and k the slice index (k = 0 is sent first). With `cfg_msb_first`=0, slice k is byte bits [kL+L-1:kL]. With `cfg_msb_first`=1, slice k is byte bits [7-kL:8-(k+1)L].
- R3: `start` is sampled while `tx_ready` is 1. The first beat is on the bus after the second rising edge that follows, and further beats come one per clock while data is available. `tx_ready` is 0 from the edge after `start` until the edge that puts the final beat on the bus.
- R4: When `cfg_eof_marker`=0 (length mode), the frame is `cfg_frame_bits`/8 bytes long and the low three bits are ignored. Last flags on the input have no effect. A `start` with fewer than 8 bits is ignored: no beat is sent and no event is raised.
- R5: When `cfg_eof_marker`=1 (marker mode), the frame ends after the byte whose `in_last` was 1, and `cfg_frame_bits` is ignored.
- R6: While no frame is active, `bus_data` equals `cfg_idle`, except that line 15 is 0 when valid or clock-gate mode is on. Reset sets `bus_data` to 0, `tx_ready` to 1 and all events to 0.
- R7: When `cfg_valid_en`=1, line 15 is 1 for every beat and 0 while idle or stalled.
- R8: When `cfg_gate_en`=1, line 15 behaves as in R7 and `bus_clk_en` equals line 15. When `cfg_gate_en`=0, `bus_clk_en` is 1.
- R9: If a frame needs data and the FIFO cannot supply it, lines 14:0 hold their last value, `evt_status` bit 0 is set, and sending resumes one clock after the missing bytes are accepted.
- R10: `evt_status` bit 2 is set on the edge that puts the final beat of a frame on the bus. Bit 1 is reserved and always 0.
- R11: Writing a 1 to an `evt_clear` bit clears that status bit on the next edge; a set in the same cycle wins. `irq` is the OR of `evt_status & evt_enable`.
- R12: `in_ready` is 1 while the FIFO (depth `FIFO_DEPTH`) is not full. A byte is accepted only when `in_valid` and `in_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 3 | Bus width code |
| cfg_msb_first | input | 1 | Slice order within a byte |
| cfg_eof_marker | input | 1 | 1: end on last flag, 0: end on bit length |
| cfg_frame_bits | input | LEN_W | Frame length in bits (length mode) |
| cfg_idle | input | 16 | Idle bus pattern |
| cfg_valid_en | input | 1 | Line 15 as valid strobe |
| cfg_gate_en | input | 1 | Line 15 as clock-gate enable |
| start | input | 1 | Begin a frame |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame (marker mode) |
| in_ready | output | 1 | FIFO can accept a byte |
| bus_data | output | 16 | Parallel output bus |
| bus_clk_en | output | 1 | Outgoing clock enable |
| tx_ready | output | 1 | Idle and able to start |
| evt_status | output | 3 | Sticky events: bit 0 empty, bit 1 reserved, bit 2 end of frame |
| evt_enable | input | 3 | Event enable mask |
| evt_clear | input | 3 | Write-1-to-clear strobes |
| irq | output | 1 | Enabled event pending |

## Verification
The bench builds the block with `FIFO_DEPTH`=8 and the default 19-bit length field. With only eight entries, a whole frame fits in the FIFO before `start`, so every width code can be swept with both slice orders and several frame lengths, and each beat compared against a value computed from the byte pattern. The shallow FIFO also makes it easy to fill the buffer and to run it dry in the middle of a frame. That brings the back-pressure, stall-hold and resume behaviour into reach next to the strobe, idle and event checks.

// File: rtl/pftx_pkg.sv
package pftx_pkg;
    localparam int BYTE_W  = 8;
    localparam int BUS_W   = 2 * BYTE_W;
    localparam int N_WCODE = 5;
    localparam int WCODE_W = 3;
    localparam int SLICE_W = 3;
    localparam int EV_W    = 3;

    localparam logic [WCODE_W-1:0] W_WIDEST = 3'd4;

    localparam int EV_EMPTY = 0;
    localparam int EV_RSVD  = 1;
    localparam int EV_EOF   = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/pftx_byte_fifo.sv
module pftx_byte_fifo
    import pftx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [BYTE_W:0]          push_entry,
    input  logic [1:0]               pop_n,
    output logic [BYTE_W:0]          head,
    output logic [BYTE_W:0]          head_next,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;
    logic [BYTE_W:0] mem_q [DEPTH];
    logic [AW-1:0]   rp_plus1;
    logic [AW-1:0]   rp_plus2;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        rp_plus1  = wrap_inc(r_q.rp);
        rp_plus2  = wrap_inc(rp_plus1);
        head      = mem_q[r_q.rp];
        head_next = mem_q[rp_plus1];
        count     = r_q.cnt;
        full      = (r_q.cnt == CW'(DEPTH));

        r_d = r_q;
        if (push) begin
            r_d.wp = wrap_inc(r_q.wp);
        end
        unique case (pop_n)
            2'd1:    r_d.rp = rp_plus1;
            2'd2:    r_d.rp = rp_plus2;
            default: r_d.rp = r_q.rp;
        endcase
        r_d.cnt = r_q.cnt + CW'(push) - CW'(pop_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[r_q.wp] <= push_entry;
        end
    end

    // R12: the engine never takes more entries than are stored
    p_pop_within_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= r_q.cnt);

    // R12: a full buffer never accepts another byte
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop_n == 2'd0) |=> (r_q.cnt == CW'(DEPTH)) && $stable(r_q.wp));
endmodule

// File: rtl/pftx_lane_mux.sv
module pftx_lane_mux
    import pftx_pkg::*;
(
    input  logic [BYTE_W-1:0]  lo_byte,
    input  logic [BYTE_W-1:0]  hi_byte,
    input  logic [WCODE_W-1:0] wcode,
    input  logic [SLICE_W-1:0] slice_idx,
    input  logic               msb_first,
    output logic [BUS_W-1:0]   beat
);
    logic [N_WCODE-1:0][BUS_W-1:0] cand;

    for (genvar c = 0; c < N_WCODE - 1; c++) begin : g_narrow
        localparam int LANES  = 1 << c;
        localparam int SLICES = BYTE_W / LANES;
        logic [3:0]        shift;
        logic [BUS_W-1:0]  val;
        int                idx;
        always_comb begin
            idx = int'(slice_idx) & (SLICES - 1);
            if (msb_first) begin
                shift = 4'(BYTE_W - (idx + 1) * LANES);
            end else begin
                shift = 4'(idx * LANES);
            end
            val = BUS_W'((lo_byte >> shift) & 8'((1 << LANES) - 1));
        end
        assign cand[c] = val;
    end

    assign cand[N_WCODE-1] = {hi_byte, lo_byte};

    always_comb begin
        unique case (wcode)
            3'd0:    beat = cand[0];
            3'd1:    beat = cand[1];
            3'd2:    beat = cand[2];
            3'd3:    beat = cand[3];
            default: beat = cand[N_WCODE-1];
        endcase
    end
endmodule

// File: rtl/pftx_events.sv
module pftx_events
    import pftx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_set,
    input  logic [EV_W-1:0] ev_clear,
    input  logic [EV_W-1:0] ev_enable,
    output logic [EV_W-1:0] status,
    output logic            irq
);
    localparam logic [EV_W-1:0] IMPL_MASK = EV_W'((1 << EV_EMPTY) | (1 << EV_EOF));

    logic [EV_W-1:0] st_d, st_q;

    always_comb begin
        st_d   = ((st_q & ~ev_clear) | ev_set) & IMPL_MASK;
        status = st_q;
        irq    = |(st_q & ev_enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: a set beats a simultaneous clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[EV_EOF] |=> status[EV_EOF]);

    // R11: a clear without a set empties the bit
    p_clear_takes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_clear[EV_EMPTY] && !ev_set[EV_EMPTY]) |=> !status[EV_EMPTY]);

    // R10: the reserved bit never rises
    p_reserved_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_set[EV_RSVD] |=> !status[EV_RSVD]);
endmodule

// File: rtl/pftx_engine.sv
module pftx_engine
    import pftx_pkg::*;
#(
    parameter int LEN_W = 19,
    parameter int CW    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WCODE_W-1:0] cfg_width,
    input  logic               cfg_msb_first,
    input  logic               cfg_eof_marker,
    input  logic [LEN_W-1:0]   cfg_frame_bits,
    input  logic [BUS_W-1:0]   cfg_idle,
    input  logic               cfg_valid_en,
    input  logic               cfg_gate_en,
    input  logic               start,
    input  logic [BYTE_W:0]    head,
    input  logic [BYTE_W:0]    head_next,
    input  logic [CW-1:0]      count,
    output logic [1:0]         pop_n,
    output logic [BYTE_W-1:0]  lo_byte,
    output logic [BYTE_W-1:0]  hi_byte,
    output logic [WCODE_W-1:0] lane_wcode,
    output logic [SLICE_W-1:0] slice_idx,
    output logic               lane_msb_first,
    input  logic [BUS_W-1:0]   beat,
    output logic [BUS_W-1:0]   bus_q,
    output logic               tx_ready,
    output logic               set_empty,
    output logic               set_eof
);
    localparam int CNT_W = LEN_W - 3;

    typedef struct packed {
        tx_state_e          state;
        logic [WCODE_W-1:0] wcode;
        logic               msb;
        logic               marker;
        logic [CNT_W-1:0]   rem;
        logic [SLICE_W-1:0] slice;
        logic [BYTE_W-1:0]  cur;
        logic               cur_last;
        logic [BUS_W-1:0]   bus;
    } eng_regs_t;

    eng_regs_t          r_d, r_q;
    logic               ovr;
    logic               emit;
    logic               fin;
    logic               need_two;
    logic               byte_last;
    logic [CNT_W-1:0]   frame_bytes;
    logic [CNT_W-1:0]   take;
    logic [SLICE_W-1:0] last_idx;

    always_comb begin
        r_d         = r_q;
        pop_n       = 2'd0;
        set_empty   = 1'b0;
        set_eof     = 1'b0;
        lo_byte     = '0;
        hi_byte     = '0;
        slice_idx   = '0;
        emit        = 1'b0;
        fin         = 1'b0;
        byte_last   = 1'b0;
        ovr         = cfg_valid_en | cfg_gate_en;
        frame_bytes = cfg_frame_bits[LEN_W-1:3];
        need_two    = r_q.marker ? !head[BYTE_W] : (r_q.rem >= CNT_W'(2));
        take        = need_two ? CNT_W'(2) : CNT_W'(1);

        unique case (r_q.wcode)
            3'd0:    last_idx = 3'd7;
            3'd1:    last_idx = 3'd3;
            3'd2:    last_idx = 3'd1;
            default: last_idx = 3'd0;
        endcase

        unique case (r_q.state)
            ST_IDLE: begin
                r_d.bus = cfg_idle;
                if (ovr) begin
                    r_d.bus[BUS_W-1] = 1'b0;
                end
                if (start && (cfg_eof_marker || frame_bytes != '0)) begin
                    r_d.state  = ST_SEND;
                    r_d.wcode  = (cfg_width > W_WIDEST) ? W_WIDEST : cfg_width;
                    r_d.msb    = cfg_msb_first;
                    r_d.marker = cfg_eof_marker;
                    r_d.rem    = frame_bytes;
                    r_d.slice  = '0;
                end
            end
            ST_SEND: begin
                if (r_q.wcode == W_WIDEST) begin
                    lo_byte = head[BYTE_W-1:0];
                    hi_byte = need_two ? head_next[BYTE_W-1:0] : '0;
                    if (count >= (need_two ? CW'(2) : CW'(1))) begin
                        emit    = 1'b1;
                        pop_n   = need_two ? 2'd2 : 2'd1;
                        r_d.rem = r_q.rem - take;
                        fin     = r_q.marker ? (!need_two || head_next[BYTE_W])
                                             : (r_q.rem == take);
                    end
                end else begin
                    slice_idx = r_q.slice;
                    if (r_q.slice == '0) begin
                        lo_byte   = head[BYTE_W-1:0];
                        byte_last = head[BYTE_W];
                        if (count != '0) begin
                            emit         = 1'b1;
                            pop_n        = 2'd1;
                            r_d.cur      = head[BYTE_W-1:0];
                            r_d.cur_last = head[BYTE_W];
                        end
                    end else begin
                        lo_byte   = r_q.cur;
                        byte_last = r_q.cur_last;
                        emit      = 1'b1;
                    end
                    if (emit) begin
                        if (r_q.slice == last_idx) begin
                            r_d.slice = '0;
                            r_d.rem   = r_q.rem - CNT_W'(1);
                            fin       = r_q.marker ? byte_last : (r_q.rem == CNT_W'(1));
                        end else begin
                            r_d.slice = r_q.slice + 1'b1;
                        end
                    end
                end

                if (emit) begin
                    r_d.bus = beat;
                    if (ovr) begin
                        r_d.bus[BUS_W-1] = 1'b1;
                    end
                    if (fin) begin
                        r_d.state = ST_IDLE;
                        set_eof   = 1'b1;
                    end
                end else begin
                    set_empty = 1'b1;
                    if (ovr) begin
                        r_d.bus[BUS_W-1] = 1'b0;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        lane_wcode     = r_q.wcode;
        lane_msb_first = r_q.msb;
        bus_q          = r_q.bus;
        tx_ready       = (r_q.state == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R4: a start with a zero byte count in length mode leaves the block idle
    p_short_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && start && !cfg_eof_marker && frame_bytes == '0) |=> tx_ready);

    // R9: during a stall the data lines keep their value
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !emit) |=> (bus_q[BUS_W-2:0] == $past(bus_q[BUS_W-2:0])));

    // R7: a stall drops the strobe on the top line
    p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_en && !tx_ready && !emit) |=> !bus_q[BUS_W-1]);

    // R3: the edge that sends the final beat returns the block to ready
    p_ready_after_eof_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_eof |=> tx_ready);

    // R10: an end event is only raised together with a beat
    p_eof_with_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_eof |-> (emit && !set_empty));
endmodule

// File: rtl/par_frame_tx.sv
module par_frame_tx
    import pftx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LEN_W      = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_width,
    input  logic               cfg_msb_first,
    input  logic               cfg_eof_marker,
    input  logic [LEN_W-1:0]   cfg_frame_bits,
    input  logic [15:0]        cfg_idle,
    input  logic               cfg_valid_en,
    input  logic               cfg_gate_en,
    input  logic               start,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    output logic               in_ready,
    output logic [15:0]        bus_data,
    output logic               bus_clk_en,
    output logic               tx_ready,
    output logic [2:0]         evt_status,
    input  logic [2:0]         evt_enable,
    input  logic [2:0]         evt_clear,
    output logic               irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [BYTE_W:0]    head;
    logic [BYTE_W:0]    head_next;
    logic [CW-1:0]      count;
    logic               full;
    logic [1:0]         pop_n;
    logic               push;
    logic [BYTE_W-1:0]  lo_byte;
    logic [BYTE_W-1:0]  hi_byte;
    logic [WCODE_W-1:0] lane_wcode;
    logic [SLICE_W-1:0] slice_idx;
    logic               lane_msb_first;
    logic [BUS_W-1:0]   beat;
    logic               set_empty;
    logic               set_eof;
    logic [EV_W-1:0]    ev_set;

    assign in_ready   = !full;
    assign push       = in_valid && !full;
    assign ev_set     = {set_eof, 1'b0, set_empty};
    assign bus_clk_en = cfg_gate_en ? bus_data[BUS_W-1] : 1'b1;

    pftx_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry ({in_last, in_data}),
        .pop_n      (pop_n),
        .head       (head),
        .head_next  (head_next),
        .count      (count),
        .full       (full)
    );

    pftx_lane_mux u_lanes (
        .lo_byte   (lo_byte),
        .hi_byte   (hi_byte),
        .wcode     (lane_wcode),
        .slice_idx (slice_idx),
        .msb_first (lane_msb_first),
        .beat      (beat)
    );

    pftx_engine #(.LEN_W(LEN_W), .CW(CW)) u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_width      (cfg_width),
        .cfg_msb_first  (cfg_msb_first),
        .cfg_eof_marker (cfg_eof_marker),
        .cfg_frame_bits (cfg_frame_bits),
        .cfg_idle       (cfg_idle),
        .cfg_valid_en   (cfg_valid_en),
        .cfg_gate_en    (cfg_gate_en),
        .start          (start),
        .head           (head),
        .head_next      (head_next),
        .count          (count),
        .pop_n          (pop_n),
        .lo_byte        (lo_byte),
        .hi_byte        (hi_byte),
        .lane_wcode     (lane_wcode),
        .slice_idx      (slice_idx),
        .lane_msb_first (lane_msb_first),
        .beat           (beat),
        .bus_q          (bus_data),
        .tx_ready       (tx_ready),
        .set_empty      (set_empty),
        .set_eof        (set_eof)
    );

    pftx_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_set    (ev_set),
        .ev_clear  (evt_clear),
        .ev_enable (evt_enable),
        .status    (evt_status),
        .irq       (irq)
    );

    // R8: with gating on, the clock enable never runs while the bus is idle
    p_gate_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gate_en && tx_ready && $past(tx_ready)) |-> !bus_clk_en);
endmodule

// File: tb/par_frame_tx_bench.sv
module par_frame_tx_bench;
    localparam int LEN_W = 19;
    localparam logic [15:0] IDLE_PAT = 16'hA5C3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_width = 3'd0;
    logic              cfg_msb_first = 1'b0;
    logic              cfg_eof_marker = 1'b0;
    logic [LEN_W-1:0]  cfg_frame_bits = '0;
    logic [15:0]       cfg_idle = IDLE_PAT;
    logic              cfg_valid_en = 1'b0;
    logic              cfg_gate_en = 1'b0;
    logic              start = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = 8'h00;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic [15:0]       bus_data;
    logic              bus_clk_en;
    logic              tx_ready;
    logic [2:0]        evt_status;
    logic [2:0]        evt_enable = 3'b000;
    logic [2:0]        evt_clear = 3'b000;
    logic              irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] fb [16];

    always #5 clk = ~clk;

    par_frame_tx #(.FIFO_DEPTH(8), .LEN_W(LEN_W)) u_par_frame_tx (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_msb_first(cfg_msb_first),
        .cfg_eof_marker(cfg_eof_marker), .cfg_frame_bits(cfg_frame_bits), .cfg_idle(cfg_idle),
        .cfg_valid_en(cfg_valid_en), .cfg_gate_en(cfg_gate_en), .start(start),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .bus_data(bus_data), .bus_clk_en(bus_clk_en), .tx_ready(tx_ready),
        .evt_status(evt_status), .evt_enable(evt_enable), .evt_clear(evt_clear), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_beat(int w, bit msb, int bi, int n, bit ovr);
        logic [15:0] v;
        int lanes, spb, j, k, sh;
        if (w >= 4) begin
            j = 2 * bi;
            v = {(j + 1 < n) ? fb[j+1] : 8'h00, fb[j]};
        end else begin
            lanes = 1 << w;
            spb = 8 / lanes;
            j = bi / spb;
            k = bi % spb;
            sh = msb ? 8 - (k + 1) * lanes : k * lanes;
            v = 16'((fb[j] >> sh) & ((1 << lanes) - 1));
        end
        if (ovr) v[15] = 1'b1;
        return v;
    endfunction

    task automatic fill_pattern(input int seed);
        for (int j = 0; j < 16; j++) fb[j] = 8'(j * 37 + seed * 11 + 5);
    endtask

    task automatic push_bytes(input int n, input int lastpos);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fb[j]; in_last = (j == lastpos);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic clear_events();
        @(negedge clk); evt_clear = 3'b111;
        @(negedge clk); evt_clear = 3'b000;
    endtask

    // Starts a prefilled frame and checks every beat (R1, R2, R3, R6, R7, R8, R10)
    task automatic start_and_check(input int w, input bit msb, input int n, input string req);
        int m;
        bit ovr;
        logic [15:0] idle_exp;
        ovr = cfg_valid_en | cfg_gate_en;
        m = (w >= 4) ? (n + 1) / 2 : n * (8 >> w);
        idle_exp = ovr ? (IDLE_PAT & 16'h7FFF) : IDLE_PAT;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R3 ready drops after start", 32'(tx_ready), 32'd0);
        for (int bi = 0; bi < m; bi++) begin
            @(negedge clk);
            chk(req, 32'(bus_data), 32'(exp_beat(w, msb, bi, n, ovr)));
            if (cfg_gate_en) chk("R8 clock enable on beat", 32'(bus_clk_en), 32'd1);
            if (bi < m - 1) chk("R3 busy within frame", 32'(tx_ready), 32'd0);
        end
        chk("R10 end event at final beat", 32'(evt_status), 32'b100);
        chk("R3 ready at final beat", 32'(tx_ready), 32'd1);
        @(negedge clk);
        chk("R6 idle pattern after frame", 32'(bus_data), 32'(idle_exp));
        chk("R8 clock enable when idle", 32'(bus_clk_en), cfg_gate_en ? 32'd0 : 32'd1);
    endtask

    task automatic run_frame(input int w, input bit msb, input int n, input bit marker,
                             input int lastpos, input string req);
        clear_events();
        cfg_width = 3'(w); cfg_msb_first = msb; cfg_eof_marker = marker;
        cfg_frame_bits = marker ? LEN_W'(8) : LEN_W'(n * 8 + 3);
        push_bytes(n, lastpos);
        start_and_check(w, msb, n, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset bus", 32'(bus_data), 32'd0);
        chk("R6 reset ready", 32'(tx_ready), 32'd1);
        chk("R6 reset events", 32'(evt_status), 32'd0);
        chk("R6 reset irq", 32'(irq), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 idle pattern", 32'(bus_data), 32'(IDLE_PAT));

        // R1, R2, R4: sweep all widths, both orders, several lengths
        for (int w = 0; w < 5; w++) begin
            for (int o = 0; o < 2; o++) begin
                for (int s = 0; s < 3; s++) begin
                    int n;
                    n = (s == 0) ? 1 : (s == 1) ? 3 : 6;
                    fill_pattern(w * 7 + o * 3 + s);
                    run_frame(w, o[0], n, 1'b0, -1, "R1 R2 R4 beat value");
                end
            end
        end

        // R5: marker mode ends on the last flag, length ignored
        for (int w = 0; w < 5; w++) begin
            fill_pattern(40 + w);
            run_frame(w, 1'b1, 5, 1'b1, 4, "R5 marker frame beat");
        end

        // R4: a last flag in length mode has no effect
        fill_pattern(60);
        run_frame(3, 1'b0, 3, 1'b0, 1, "R4 last flag ignored");

        // R1: width code above 4 behaves as 16 lines
        fill_pattern(61);
        run_frame(6, 1'b0, 4, 1'b0, -1, "R1 code 6 as 16 lines");

        // R7: valid strobe on line 15
        cfg_valid_en = 1'b1;
        fill_pattern(62);
        run_frame(2, 1'b0, 2, 1'b0, -1, "R7 valid strobe beat");
        cfg_valid_en = 1'b0;

        // R8: clock-gate mode
        cfg_gate_en = 1'b1;
        fill_pattern(63);
        run_frame(1, 1'b1, 2, 1'b0, -1, "R8 gate strobe beat");
        cfg_gate_en = 1'b0;

        // R11: enable mask and write-1 clear
        evt_enable = 3'b100;
        @(negedge clk);
        chk("R11 irq from enabled end event", 32'(irq), 32'd1);
        evt_enable = 3'b001;
        @(negedge clk);
        chk("R11 irq masked", 32'(irq), 32'd0);
        evt_clear = 3'b100;
        @(negedge clk);
        evt_clear = 3'b000;
        chk("R11 end event cleared", 32'(evt_status), 32'd0);

        // R4: start with fewer than 8 bits is ignored
        cfg_eof_marker = 1'b0; cfg_frame_bits = LEN_W'(5);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R4 short start keeps ready", 32'(tx_ready), 32'd1);
        chk("R4 short start keeps idle", 32'(bus_data), 32'(IDLE_PAT));
        chk("R4 short start raises nothing", 32'(evt_status), 32'd0);

        // R9: stall in the middle of a frame, then resume
        cfg_valid_en = 1'b1; cfg_width = 3'd3; cfg_msb_first = 1'b0;
        cfg_frame_bits = LEN_W'(32);
        fill_pattern(70);
        push_bytes(2, -1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R9 beat before stall", 32'(bus_data), 32'({1'b1, 7'b0, fb[0]}));
        @(negedge clk);
        chk("R9 beat before stall", 32'(bus_data), 32'({1'b1, 7'b0, fb[1]}));
        @(negedge clk);
        chk("R9 stall holds data", 32'(bus_data), 32'({1'b0, 7'b0, fb[1]}));
        chk("R9 empty event", 32'(evt_status), 32'b001);
        in_valid = 1'b1; in_data = fb[2];
        @(negedge clk);
        chk("R7 strobe low while stalled", 32'(bus_data[15]), 32'd0);
        in_data = fb[3];
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 resume third beat", 32'(bus_data), 32'({1'b1, 7'b0, fb[2]}));
        @(negedge clk);
        chk("R9 resume fourth beat", 32'(bus_data), 32'({1'b1, 7'b0, fb[3]}));
        chk("R10 end after stall", 32'(evt_status), 32'b101);
        cfg_valid_en = 1'b0;

        // R12: fill the buffer, extra byte refused
        clear_events();
        fill_pattern(80);
        push_bytes(8, -1);
        chk("R12 full drops ready", 32'(in_ready), 32'd0);
        in_valid = 1'b1; in_data = 8'hEE;
        @(negedge clk);
        in_valid = 1'b0;
        cfg_width = 3'd3; cfg_frame_bits = LEN_W'(64);
        start_and_check(3, 1'b0, 8, "R12 buffered bytes");
        chk("R12 ready after drain", 32'(in_ready), 32'd1);
        clear_events();
        cfg_frame_bits = LEN_W'(8);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R12 refused byte never sent", 32'(bus_data), 32'(IDLE_PAT));
        chk("R9 empty event on dry start", 32'(evt_status), 32'b001);
        fb[0] = 8'h3C;
        push_bytes(1, -1);
        @(negedge clk);
        chk("R9 frame completes after data", 32'(tx_ready), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule